// File: doc/BRIEF.md
# I2C EEPROM Page-Write Sequencer with Acknowledge Polling

This block is the host side of a serial EEPROM write. It takes one request: a 7-bit device address, a starting word address and a byte count from 1 to the page size. It then pulls the data bytes one at a time over a valid/ready stream and walks an external bit-level I2C engine through the whole write. The engine receives one command at a time: START, send a byte, or STOP. For each byte it sends, the engine reports whether the slave acknowledged.

After the STOP that commits the write, the block does not wait a fixed programming time. It probes the device straight away with START followed by the device address with the write direction bit. It repeats that probe, with a STOP between attempts, until the device acknowledges. A parameter bounds the number of probes. The block finishes with a STOP and then raises a one-cycle completion pulse with an error flag. A request that would run past the end of a page is refused before any bus activity, so the device's page counter can never wrap and overwrite earlier bytes. A missing acknowledge during the write itself ends the transfer with STOP and an error.

Top module: `eeprom_wr_seq`

## Requirements
- R1: While reset is held and just after it is released, `req_ready` is 1, and `eng_cmd_valid`, `wdata_ready`, `done` and `err` are 0.
- R2: An accepted request produces these engine commands in this order: START (code 1), a send-byte (code 2) of `{req_dev,0}`, a send-byte of `req_word`, one send-byte for each data byte in stream order, then STOP (code 3). `eng_byte` is 0 for START and STOP.
- R3: A request with count 0, a count above the page size (16), or a count that makes `req_word[3:0] + count` exceed 16 is refused. `done` and `err` are both 1 in the cycle after acceptance, and no engine command is issued.
- R4: Exactly one data byte is consumed per cycle with `wdata_valid && wdata_ready`. A byte is pulled only when it is the next to be sent, so a write aborted after k acknowledged data bytes consumes k+1 bytes.
- R5: A missing acknowledge on the device, word or data byte of the write is followed by STOP and then `done` with `err`=1. No probe follows.
- R6: The STOP that ends a fully acknowledged write is followed at once by a probe: START, then a send-byte of `{req_dev,0}`.
- R7: A probe that is not acknowledged is followed by STOP and then a new probe.
- R8: An acknowledged probe is followed by STOP and then `done` with `err`=0.
- R9: When POLL_MAX probes (default 8) in a row are not acknowledged, the last one is followed by STOP and `done` with `err`=1. If POLL_MAX-1 probes fail and the next succeeds, the request completes without error.
- R10: `done` lasts exactly one cycle. `err` is 1 only together with `done`. `req_ready` is 0 while a request is in progress.
- R11: A command stays on `eng_cmd_valid`/`eng_cmd`/`eng_byte` unchanged until the cycle in which `eng_done` is sampled. `eng_ack` is read together with `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_dev | input | 7 | 7-bit device address |
| req_word | input | 8 | Starting word address |
| req_count | input | CNT_W (5) | Number of data bytes |
| wdata_valid | input | 1 | Data byte offered |
| wdata_ready | output | 1 | Data byte taken this cycle if valid |
| wdata | input | 8 | Data byte |
| eng_cmd_valid | output | 1 | Command presented to the bit engine |
| eng_cmd | output | 2 | 1 START, 2 send byte, 3 STOP |
| eng_byte | output | 8 | Byte for a send-byte command |
| eng_done | input | 1 | Engine finished the current command (one cycle) |
| eng_ack | input | 1 | Slave acknowledged the sent byte, qualified by eng_done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion ended in failure (with done) |

## Verification
A corrupted phase or stop-outcome state shows at the engine port as the wrong next command. The next command after an `eng_done` could be an extra probe, a missing STOP, or a data byte where a probe belongs. The bench compares every command against its scoreboard when the command appears, so the fault is caught within one engine command of its cause. A wrong byte counter or stream gate shows as an unexpected byte count at the data port or a wrong byte value on the bus. A wrong probe counter shows as a completion arriving one probe early or late, with a wrong error flag.

// File: rtl/eews_pkg.sv
package eews_pkg;
    localparam int DEV_W  = 7;
    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_START = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } bus_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_START,
        ST_W_DEV,
        ST_W_WORD,
        ST_W_LOAD,
        ST_W_DATA,
        ST_STOP,
        ST_P_START,
        ST_P_DEV
    } seq_state_e;

    // what happens once the pending STOP has been sent
    typedef enum logic [1:0] {
        AFT_POLL,
        AFT_RETRY,
        AFT_OK,
        AFT_FAIL
    } after_stop_e;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [WORD_W-1:0] word;
    } wr_target_t;

    function automatic logic page_fits(int unsigned offset, int unsigned count,
                                       int unsigned page);
        return (count != 0) && (count <= page) && (offset + count <= page);
    endfunction

    function automatic logic [WORD_W-1:0] dev_write_byte(logic [DEV_W-1:0] dev);
        return {dev, 1'b0};
    endfunction
endpackage

// File: rtl/eews_req_gate.sv
module eews_req_gate
    import eews_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int CNT_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              req_valid,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [WORD_W-1:0] req_word,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_ready,
    output logic              take_ok,
    output logic              take_bad,
    output wr_target_t        tgt_q,
    output logic [CNT_W-1:0]  cnt_q
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [OFF_W-1:0] offset;
    logic             fits;

    assign req_ready = idle;
    assign offset    = req_word[OFF_W-1:0];
    assign fits      = page_fits(32'(offset), 32'(req_count), PAGE_BYTES);
    assign take_ok   = req_valid && req_ready && fits;
    assign take_bad  = req_valid && req_ready && !fits;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            cnt_q <= '0;
        end else if (take_ok) begin
            tgt_q.dev  <= req_dev;
            tgt_q.word <= req_word;
            cnt_q      <= req_count;
        end
    end

    // a latched count always fits inside one page
    assert_count_in_page_R3: assert property (@(posedge clk) disable iff (rst)
        take_ok |=> (cnt_q != '0) && (32'(cnt_q) <= PAGE_BYTES));
endmodule

// File: rtl/eews_retry_ctr.sv
module eews_retry_ctr #(
    parameter int POLL_MAX = 8,
    parameter int CW       = $clog2(POLL_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(POLL_MAX - 1));

    assert_retry_bound_R9: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < POLL_MAX);
    assert_no_inc_at_limit_R9: assert property (@(posedge clk) disable iff (rst)
        inc |-> !last);
endmodule

// File: rtl/eews_fsm.sv
module eews_fsm
    import eews_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_ok,
    input  logic              take_bad,
    input  wr_target_t        tgt_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic              idle,
    input  logic              wdata_valid,
    input  logic [WORD_W-1:0] wdata,
    output logic              wdata_ready,
    output logic              eng_cmd_valid,
    output bus_cmd_e          eng_cmd,
    output logic [WORD_W-1:0] eng_byte,
    input  logic              eng_done,
    input  logic              eng_ack,
    output logic              retry_clr,
    output logic              retry_inc,
    input  logic              retry_last,
    output logic              done,
    output logic              err
);
    seq_state_e        st;
    after_stop_e       aft;
    logic [CNT_W-1:0]  sent;
    logic [WORD_W-1:0] dbuf;

    assign idle        = (st == ST_IDLE);
    assign wdata_ready = (st == ST_W_LOAD);
    assign retry_clr   = take_ok;
    assign retry_inc   = (st == ST_P_DEV) && eng_done && !eng_ack && !retry_last;

    always_comb begin
        eng_cmd_valid = 1'b1;
        eng_cmd       = CMD_NONE;
        eng_byte      = '0;
        unique case (st)
            ST_W_START, ST_P_START: eng_cmd = CMD_START;
            ST_W_DEV, ST_P_DEV: begin
                eng_cmd  = CMD_WRITE;
                eng_byte = dev_write_byte(tgt_q.dev);
            end
            ST_W_WORD: begin
                eng_cmd  = CMD_WRITE;
                eng_byte = tgt_q.word;
            end
            ST_W_DATA: begin
                eng_cmd  = CMD_WRITE;
                eng_byte = dbuf;
            end
            ST_STOP: eng_cmd = CMD_STOP;
            default: eng_cmd_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            aft  <= AFT_OK;
            sent <= '0;
            dbuf <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    sent <= '0;
                    if (take_ok) begin
                        st <= ST_W_START;
                    end else if (take_bad) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end
                end
                ST_W_START: if (eng_done) st <= ST_W_DEV;
                ST_W_DEV: if (eng_done) begin
                    if (eng_ack) st <= ST_W_WORD;
                    else begin aft <= AFT_FAIL; st <= ST_STOP; end
                end
                ST_W_WORD: if (eng_done) begin
                    if (eng_ack) st <= ST_W_LOAD;
                    else begin aft <= AFT_FAIL; st <= ST_STOP; end
                end
                ST_W_LOAD: if (wdata_valid) begin
                    dbuf <= wdata;
                    st   <= ST_W_DATA;
                end
                ST_W_DATA: if (eng_done) begin
                    if (!eng_ack) begin
                        aft <= AFT_FAIL;
                        st  <= ST_STOP;
                    end else if (sent + 1'b1 == cnt_q) begin
                        aft <= AFT_POLL;
                        st  <= ST_STOP;
                    end else begin
                        sent <= sent + 1'b1;
                        st   <= ST_W_LOAD;
                    end
                end
                ST_STOP: if (eng_done) begin
                    unique case (aft)
                        AFT_POLL, AFT_RETRY: st <= ST_P_START;
                        AFT_OK: begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end
                        AFT_FAIL: begin
                            done <= 1'b1;
                            err  <= 1'b1;
                            st   <= ST_IDLE;
                        end
                    endcase
                end
                ST_P_START: if (eng_done) st <= ST_P_DEV;
                ST_P_DEV: if (eng_done) begin
                    if (eng_ack)         aft <= AFT_OK;
                    else if (retry_last) aft <= AFT_FAIL;
                    else                 aft <= AFT_RETRY;
                    st <= ST_STOP;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_valid && !eng_done |=> eng_cmd_valid && $stable(eng_cmd) && $stable(eng_byte));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
    assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        take_bad |=> done && err && !eng_cmd_valid);
    assert_write_dir_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_W_DEV || st == ST_P_DEV) |-> !eng_byte[0]);
    assert_no_data_pull_out_of_write_R4: assert property (@(posedge clk) disable iff (rst)
        wdata_ready |-> !eng_cmd_valid && (sent < cnt_q));
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
    import eews_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int POLL_MAX   = 8,
    parameter int CNT_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [WORD_W-1:0] req_word,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    input  logic [WORD_W-1:0] wdata,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_cmd,
    output logic [WORD_W-1:0] eng_byte,
    input  logic              eng_done,
    input  logic              eng_ack,
    output logic              done,
    output logic              err
);
    logic             idle, take_ok, take_bad;
    logic             retry_clr, retry_inc, retry_last;
    wr_target_t       tgt_q;
    logic [CNT_W-1:0] cnt_q;
    bus_cmd_e         cmd_e;

    eews_req_gate #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) gate_i (
        .clk(clk), .rst(rst), .idle(idle),
        .req_valid(req_valid), .req_dev(req_dev), .req_word(req_word),
        .req_count(req_count), .req_ready(req_ready),
        .take_ok(take_ok), .take_bad(take_bad),
        .tgt_q(tgt_q), .cnt_q(cnt_q)
    );

    eews_retry_ctr #(.POLL_MAX(POLL_MAX)) retry_i (
        .clk(clk), .rst(rst), .clr(retry_clr), .inc(retry_inc), .last(retry_last)
    );

    eews_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst(rst),
        .take_ok(take_ok), .take_bad(take_bad), .tgt_q(tgt_q), .cnt_q(cnt_q),
        .idle(idle),
        .wdata_valid(wdata_valid), .wdata(wdata), .wdata_ready(wdata_ready),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd(cmd_e), .eng_byte(eng_byte),
        .eng_done(eng_done), .eng_ack(eng_ack),
        .retry_clr(retry_clr), .retry_inc(retry_inc), .retry_last(retry_last),
        .done(done), .err(err)
    );

    assign eng_cmd = cmd_e;
endmodule

// File: tb/eeprom_wr_seq_tb_top.sv
module eeprom_wr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int POLLS      = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [6:0] req_dev = '0;
    logic [7:0] req_word = '0;
    logic [4:0] req_count = '0;
    logic       wdata_valid;
    logic       wdata_ready;
    logic [7:0] wdata;
    logic       eng_cmd_valid;
    logic [1:0] eng_cmd;
    logic [7:0] eng_byte;
    logic       eng_done;
    logic       eng_ack;
    logic       done, err;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_wr_seq #(.PAGE_BYTES(16), .POLL_MAX(POLLS)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
        .req_word(req_word), .req_count(req_count),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_byte(eng_byte),
        .eng_done(eng_done), .eng_ack(eng_ack), .done(done), .err(err)
    );

    typedef struct {
        logic [1:0] c;
        logic [7:0] b;
        logic       a;
    } item_t;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    reported = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    endtask

    // data stream source
    logic [7:0] data_buf [16];
    int  taken_total = 0;
    int  cyc = 0;
    int  base = 0;
    int  feed_n = 0;
    bit  feed_stall = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wdata_valid && wdata_ready) taken_total <= taken_total + 1;
    end

    always @(negedge clk) begin
        int idx;
        idx = taken_total - base;
        wdata_valid = (idx < feed_n) && !(feed_stall && (cyc % 4 != 0));
        wdata = (idx >= 0 && idx < 16) ? data_buf[idx] : 8'h00;
    end

    // bit-engine model and scoreboard monitor
    initial begin
        item_t cur;
        bit    busy;
        int    dly;
        busy = 0; dly = 0;
        cur = '{2'd0, 8'd0, 1'b0};
        eng_done = 1'b0;
        eng_ack  = 1'b0;
        forever begin
            @(negedge clk);
            if (eng_done) begin
                eng_done = 1'b0;
                eng_ack  = 1'b0;
                busy     = 0;
            end else if (busy) begin
                if (!eng_cmd_valid || eng_cmd != cur.c || eng_byte != cur.b)
                    chk(0, "R11 command changed before eng_done", int'(eng_cmd), int'(cur.c));
                if (dly == 0) begin
                    eng_done = 1'b1;
                    eng_ack  = cur.a;
                end else dly--;
            end else if (eng_cmd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected command", int'(eng_cmd), 0);
                    cur = '{eng_cmd, eng_byte, 1'b1};
                end else begin
                    cur = exp_q.pop_front();
                    chk(eng_cmd == cur.c, "R2 command code", int'(eng_cmd), int'(cur.c));
                    chk(eng_byte == cur.b, "R2 command byte", int'(eng_byte), int'(cur.b));
                end
                busy = 1;
                dly  = 1;
            end
        end
    end

    task automatic push(input logic [1:0] c, input logic [7:0] b, input logic a);
        exp_q.push_back('{c, b, a});
    endtask

    task automatic fill(input logic [6:0] dev, input logic [7:0] word);
        for (int i = 0; i < 16; i++) data_buf[i] = 8'(int'(dev) + i * 29 + int'(word));
    endtask

    // nack_at: -1 none, 0 device byte, 1 word byte, 2+k data byte k
    task automatic push_write(input logic [6:0] dev, input logic [7:0] word,
                              input int cnt, input int nack_at);
        push(2'd1, 8'h00, 1'b1);
        push(2'd2, {dev, 1'b0}, nack_at != 0);
        if (nack_at == 0) begin push(2'd3, 8'h00, 1'b1); return; end
        push(2'd2, word, nack_at != 1);
        if (nack_at == 1) begin push(2'd3, 8'h00, 1'b1); return; end
        for (int k = 0; k < cnt; k++) begin
            push(2'd2, data_buf[k], nack_at != k + 2);
            if (nack_at == k + 2) break;
        end
        push(2'd3, 8'h00, 1'b1);
    endtask

    task automatic push_polls(input logic [6:0] dev, input int busy_n, input bit final_ack);
        for (int p = 0; p < busy_n; p++) begin
            push(2'd1, 8'h00, 1'b1);
            push(2'd2, {dev, 1'b0}, 1'b0);
            push(2'd3, 8'h00, 1'b1);
        end
        if (final_ack) begin
            push(2'd1, 8'h00, 1'b1);
            push(2'd2, {dev, 1'b0}, 1'b1);
            push(2'd3, 8'h00, 1'b1);
        end
    endtask

    task automatic run_req(input logic [6:0] dev, input logic [7:0] word, input int cnt,
                           input bit stall, input bit rejected, input bit exp_err,
                           input int exp_taken, input string tag);
        bit seen;
        @(negedge clk);
        base       = taken_total;
        feed_n     = cnt;
        feed_stall = stall;
        req_valid  = 1'b1;
        req_dev    = dev;
        req_word   = word;
        req_count  = 5'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        if (rejected) begin
            chk(done === 1'b1 && err === 1'b1, {"R3 reject pulse ", tag}, int'(done), 1);
            chk(eng_cmd_valid === 1'b0, {"R3 no bus command ", tag}, int'(eng_cmd_valid), 0);
        end else begin
            chk(req_ready === 1'b0, {"R10 busy not ready ", tag}, int'(req_ready), 0);
            seen = 0;
            for (int t = 0; t < 4000 && !seen; t++) begin
                @(negedge clk);
                if (done === 1'b1) seen = 1;
            end
            chk(seen, {"R10 done arrives ", tag}, int'(seen), 1);
            chk(err === exp_err, {"R5 R8 R9 err flag ", tag}, int'(err), int'(exp_err));
        end
        chk(exp_q.size() == 0, {"R2 all commands seen ", tag}, exp_q.size(), 0);
        @(negedge clk);
        chk(done === 1'b0 && err === 1'b0, {"R10 done one cycle ", tag}, int'(done), 0);
        chk(taken_total - base == exp_taken, {"R4 bytes consumed ", tag},
            taken_total - base, exp_taken);
        feed_n = 0;
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready === 1'b1 && eng_cmd_valid === 1'b0 && done === 1'b0 &&
            err === 1'b0 && wdata_ready === 1'b0, "R1 reset state", int'(eng_cmd_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && eng_cmd_valid === 1'b0 && done === 1'b0,
            "R1 after reset", int'(req_ready), 1);

        // R2 R6 R8: single byte, device ready at first probe
        fill(7'h50, 8'h0F);
        push_write(7'h50, 8'h0F, 1, -1);
        push_polls(7'h50, 0, 1);
        run_req(7'h50, 8'h0F, 1, 0, 0, 0, 1, "single");

        // R7: full page with two busy probes, stalled stream (R4)
        fill(7'h2A, 8'h20);
        push_write(7'h2A, 8'h20, 16, -1);
        push_polls(7'h2A, 2, 1);
        run_req(7'h2A, 8'h20, 16, 1, 0, 0, 16, "page16");

        // R3: rejected requests
        run_req(7'h11, 8'h40, 0, 0, 1, 1, 0, "count0");
        run_req(7'h11, 8'h40, 17, 0, 1, 1, 0, "count17");
        run_req(7'h11, 8'h0E, 3, 0, 1, 1, 0, "cross");

        // R5: nack on data byte 1 of 3, nack on device, nack on word
        fill(7'h33, 8'h61);
        push_write(7'h33, 8'h61, 3, 3);
        run_req(7'h33, 8'h61, 3, 0, 0, 1, 2, "data_nack");
        fill(7'h34, 8'h00);
        push_write(7'h34, 8'h00, 4, 0);
        run_req(7'h34, 8'h00, 4, 0, 0, 1, 0, "dev_nack");
        fill(7'h35, 8'h08);
        push_write(7'h35, 8'h08, 8, 1);
        run_req(7'h35, 8'h08, 8, 0, 0, 1, 0, "word_nack");

        // R9: probe limit reached, then one below the limit
        fill(7'h44, 8'h73);
        push_write(7'h44, 8'h73, 2, -1);
        push_polls(7'h44, POLLS, 0);
        run_req(7'h44, 8'h73, 2, 0, 0, 1, 2, "poll_limit");
        fill(7'h45, 8'h90);
        push_write(7'h45, 8'h90, 5, -1);
        push_polls(7'h45, POLLS - 1, 1);
        run_req(7'h45, 8'h90, 5, 1, 0, 0, 5, "poll_edge");

        repeat (3) @(negedge clk);
        report();
    end
endmodule